// File: doc/BRIEF.md
# Crosspoint Switch Control Memory

This block keeps the on/off state of every crosspoint in a switch matrix of 16 rows by 8 columns, one storage bit per crosspoint, 128 bits in all. A host picks one crosspoint with a row address and a column address and presents the new state on a data line. It then raises a chip select and pulses a strobe. The 128 stored bits drive the switch enables directly. The host cannot read the memory back.

The host-side controls are treated as asynchronous to the system clock. Strobe, chip select, data and both addresses pass together through a two-stage synchronizer. The block then acts on the sampled values. While the sampled strobe and chip select are both high, the addressed cell is transparent and follows the data line. When the strobe falls, the cell keeps the last value it followed. A synchronous active-high reset clears every cell and blocks all writes while it is held. Chip select has no influence on reset.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While reset is held, and on the first sample after it is released, all 128 switch-enable outputs are 0.
- R2: The crosspoint at row r (0..15) and column c (0..7) drives output bit c*16 + r. This is the 7-bit value {column, row}.
- R3: A write with data 1 turns the addressed enable on, and a write with data 0 turns it off.
- R4: While strobe and chip select are both high, the addressed enable follows every change of the data line.
- R5: After the strobe falls, the addressed cell keeps the data value it held when the strobe was sampled low. Later changes on the data line have no effect.
- R6: A write changes only the addressed bit. The other 127 bits keep their values.
- R7: Reset clears all cells whatever the level of chip select. Strobe activity during reset leaves every output at 0.
- R8: While chip select is low, strobe pulses and data changes leave every output unchanged.
- R9: A change on the host inputs reaches the outputs on the third rising clock edge after the change. It does not reach them earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; clears all cells |
| row_addr | input | 4 | Row of the addressed crosspoint |
| col_addr | input | 3 | Column of the addressed crosspoint |
| data_in | input | 1 | New state for the addressed crosspoint (1 = on) |
| sel | input | 1 | Chip select, active high |
| strobe | input | 1 | Write strobe, active high; the cell is transparent while high and frozen on its fall |
| xpt_en | output | 128 | Switch enables, bit c*16 + r for row r, column c |

## Verification
The memory is the only state in the block, and every bit of it is driven straight to an output. A wrong cell therefore shows up at the ports on the same edge that corrupts it, three edges after the host input that caused it. A decoder fault that hits a neighbouring cell shows as a second changed bit. A missed freeze shows as a bit that follows the data line after the strobe has fallen. A bad reset or chip-select gate shows as a nonzero pattern where the bench expects either all zeros or an unchanged pattern. The bench compares the full 128-bit vector with its own model after every step.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    // Host control sample carried through the synchronizer.
    typedef struct packed {
        logic stb;
        logic sel;
        logic data;
    } xpt_ctl_t;

    localparam int DEF_ROWS   = 16;
    localparam int DEF_COLS   = 8;
    localparam int DEF_STAGES = 2;

    // Flat position of a crosspoint: column-major, rows inner.
    function automatic int cell_index(input int col, input int row, input int rows);
        return col * rows + row;
    endfunction

endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/xpt_wr_ctrl.sv
module xpt_wr_ctrl
    import xpt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  xpt_ctl_t ctl,
    output logic     wr_en,
    output logic     commit
);
    logic prev_active;

    always_comb wr_en = ctl.stb && ctl.sel;

    always_ff @(posedge clk) begin
        if (rst) prev_active <= 1'b0;
        else     prev_active <= wr_en;
    end

    // Falling edge of the sampled strobe after a selected window.
    always_comb commit = prev_active && !ctl.stb;
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array
    import xpt_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int COLS = DEF_COLS,
    localparam int RAW   = $clog2(ROWS),
    localparam int CAW   = $clog2(COLS),
    localparam int CELLS = ROWS * COLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RAW-1:0]   row,
    input  logic [CAW-1:0]   col,
    input  logic             data,
    output logic [CELLS-1:0] cells
);
    logic [CELLS-1:0] hit;

    for (genvar g = 0; g < CELLS; g++) begin : g_dec
        localparam int GR = g % ROWS;
        localparam int GC = g / ROWS;
        always_comb hit[g] = wr_en && (row == RAW'(GR)) && (col == CAW'(GC));
    end

    always_ff @(posedge clk) begin
        if (rst) cells <= '0;
        else     cells <= (cells & ~hit) | (data ? hit : '0);
    end

    logic [$clog2(CELLS)-1:0] widx;
    always_comb widx = ($clog2(CELLS))'(cell_index(int'(col), int'(row), ROWS));

    // R7: reset leaves every cell cleared
    a_r7_reset_clears: assert property (@(posedge clk) rst |=> (cells == '0));

    // R3 / R4: an enabled write lands the sampled data in the addressed cell
    a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (cells[$past(widx)] == $past(data)));

    // R6: at most one cell changes per edge outside reset
    a_r6_single_cell: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $onehot0(cells ^ $past(cells)));
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
    import xpt_pkg::*;
#(
    parameter int ROWS        = DEF_ROWS,
    parameter int COLS        = DEF_COLS,
    parameter int SYNC_STAGES = DEF_STAGES,
    localparam int RAW   = $clog2(ROWS),
    localparam int CAW   = $clog2(COLS),
    localparam int CELLS = ROWS * COLS,
    localparam int SW    = $bits(xpt_ctl_t) + CAW + RAW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RAW-1:0]   row_addr,
    input  logic [CAW-1:0]   col_addr,
    input  logic             data_in,
    input  logic             sel,
    input  logic             strobe,
    output logic [CELLS-1:0] xpt_en
);
    xpt_ctl_t       raw_ctl, s_ctl;
    logic [RAW-1:0] s_row;
    logic [CAW-1:0] s_col;
    logic [SW-1:0]  sync_in, sync_out;
    logic           wr_en, commit;

    always_comb begin
        raw_ctl.stb  = strobe;
        raw_ctl.sel  = sel;
        raw_ctl.data = data_in;
        sync_in      = {raw_ctl, col_addr, row_addr};
    end

    xpt_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    always_comb {s_ctl, s_col, s_row} = sync_out;

    xpt_wr_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .ctl    (s_ctl),
        .wr_en  (wr_en),
        .commit (commit)
    );

    xpt_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .row   (s_row),
        .col   (s_col),
        .data  (s_ctl.data),
        .cells (xpt_en)
    );

    // R8: a deselected sample never alters the memory
    a_r8_deselect_holds: assert property (@(posedge clk) disable iff (rst)
        !s_ctl.sel |=> $stable(xpt_en));

    // R5: the memory is frozen on the edge that follows a strobe fall
    a_r5_frozen_at_fall: assert property (@(posedge clk) disable iff (rst)
        commit |=> $stable(xpt_en));
endmodule

// File: tb/sim_xpt_ctrl_mem.sv
module sim_xpt_ctrl_mem;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   row_addr = '0;
    logic [2:0]   col_addr = '0;
    logic         data_in = 1'b0;
    logic         sel = 1'b0;
    logic         strobe = 1'b0;
    logic [127:0] xpt_en;
    logic [127:0] model = '0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    xpt_ctrl_mem u0 (
        .clk(clk), .rst(rst), .row_addr(row_addr), .col_addr(col_addr),
        .data_in(data_in), .sel(sel), .strobe(strobe), .xpt_en(xpt_en)
    );

    function automatic int idx(input int c, input int r);
        return c * 16 + r;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [127:0] exp);
        checks++;
        if (xpt_en !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, xpt_en, exp);
        end
    endtask

    task automatic do_write(input int r, input int c, input logic d, input logic s, input string req);
        row_addr = 4'(r); col_addr = 3'(c); data_in = d; sel = s; strobe = 1'b0;
        step(3);
        strobe = 1'b1;
        step(3);
        if (s) model[idx(c, r)] = d;
        chk(req, model);
        strobe = 1'b0;
        step(3);
        chk(req, model);
        sel = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed));
        @(negedge clk);
        step(3);
        chk("R1 reset state", '0);
        rst = 1'b0;
        step(1);
        chk("R1 after release", '0);

        // R9 latency: all inputs change together at a negedge
        row_addr = 4'd2; col_addr = 3'd1; data_in = 1'b1; sel = 1'b1; strobe = 1'b1;
        step(2);
        chk("R9 not before third edge", '0);
        step(1);
        model[idx(1, 2)] = 1'b1;
        chk("R9 at third edge", model);
        strobe = 1'b0; sel = 1'b0;
        step(3);

        // R2 mapping: row 5, column 3 -> bit 53
        do_write(5, 3, 1'b1, 1'b1, "R2 bit index");
        chk("R2 exact pattern", (128'd1 << 53) | (128'd1 << 18));

        // R3 on then off
        do_write(0, 0, 1'b1, 1'b1, "R3 turn on");
        do_write(0, 0, 1'b0, 1'b1, "R3 turn off");

        // R4 transparency on cell 127, then R5 freeze
        row_addr = 4'd15; col_addr = 3'd7; sel = 1'b1; data_in = 1'b0;
        step(3);
        strobe = 1'b1;
        for (int k = 0; k < 4; k++) begin
            data_in = k[0] ? 1'b0 : 1'b1;
            step(3);
            model[127] = data_in;
            chk("R4 follow data", model);
        end
        data_in = 1'b1;
        step(3);
        model[127] = 1'b1;
        strobe = 1'b0;
        step(1);
        data_in = 1'b0;
        step(4);
        chk("R5 frozen after fall", model);
        sel = 1'b0;

        // R6 / R3 random writes, some deselected (R8)
        for (int n = 0; n < 40; n++) begin
            automatic int r = int'($urandom % 16);
            automatic int c = int'($urandom % 8);
            automatic logic d = 1'($urandom);
            automatic logic s = ($urandom % 4) != 0;
            do_write(r, c, d, s, s ? "R6 random write" : "R8 random deselected");
        end

        // R8 directed: strobe and data activity with chip select low
        model[idx(4, 9)] = 1'b1;
        do_write(9, 4, 1'b1, 1'b1, "R6 set before R8");
        do_write(9, 4, 1'b0, 1'b0, "R8 clear attempt ignored");
        do_write(10, 6, 1'b1, 1'b0, "R8 set attempt ignored");
        chk("R8 pattern intact", model);

        // R7: reset with chip select low and strobe high
        sel = 1'b0; strobe = 1'b1; rst = 1'b1;
        step(2);
        model = '0;
        chk("R7 reset with select low", model);
        strobe = 1'b0; rst = 1'b0;
        step(3);
        chk("R7 cleared after release", model);

        // R7: write attempt during reset is ignored
        do_write(3, 2, 1'b1, 1'b1, "R3 set before R7");
        rst = 1'b1;
        row_addr = 4'd7; col_addr = 3'd5; data_in = 1'b1; sel = 1'b1; strobe = 1'b1;
        step(4);
        model = '0;
        chk("R7 write during reset", model);
        strobe = 1'b0;
        step(3);
        rst = 1'b0; sel = 1'b0;
        step(3);
        chk("R7 no write after reset", model);

        finish_run();
    end
endmodule